// File: doc/BRIEF.md
# Set-Associative Data Cache With Line Fill

This block is a byte-wide read/write data cache that sits between a requester and a wider backing memory. Its storage is arranged as 64 sets of 8 ways with 64-byte lines, 32768 bytes in all. A requester presents one byte access at a time under a valid/ready handshake. The block looks the address up in the indexed set. A hit completes locally. A miss picks a way to replace, copies that way back to memory if it holds modified data, and then fetches the new line before it completes the access.

The memory side moves one 8-byte beat per handshake. A whole line always takes eight beats, in rising address order from the line's aligned base. A small controller orders the steps of each access: lookup, optional copy-back, fetch, and response. Only one access is in flight at a time, and the requester sees a one-cycle response pulse carrying the read byte.

Top module: `sa_cache`

## Requirements
- R1: After reset the block is idle (`cpu_ready` high, `cpu_resp` low, `mem_valid` low) and every line is empty, so the first access to any line misses.
- R2: Address bits [5:0] select the byte inside a line, bits [11:6] select the set, and bits [31:12] form the tag. Byte k of a line is byte k mod 8 (bits [8*(k mod 8)+7 : 8*(k mod 8)]) of memory beat k/8.
- R3: A hit is found by comparing the tag against all 8 ways of the indexed set. The response pulse comes exactly two cycles after the accepting edge, with no memory beat.
- R4: A read returns the byte most recently written to that address through the block, or else the backing memory's content.
- R5: A write that hits updates only the addressed byte and marks the line modified. When that line is later replaced, its bytes, including the written one, are copied back to memory.
- R6: A miss whose chosen way is empty or unmodified issues exactly 8 read beats and no write beat.
- R7: A miss whose chosen way is modified issues exactly 8 write beats for the old line's address, all before the first of 8 read beats for the new line.
- R8: The beats of one line go in ascending order from the line-aligned base, 8 bytes apart. A beat moves only when `mem_valid` and `mem_ready` are both high, and the address and direction stay unchanged while the beat is stalled.
- R9: On a miss the lowest-numbered empty way of the set is taken. If all 8 ways are occupied, the way comes from a per-set counter that starts at 0 and advances by one on each such replacement, wrapping after 7.
- R10: A write that misses first fetches the line and then writes the byte into it; the next lookup after a fetch hits.
- R11: Up to 8 lines with the same set bits and different tags reside together, and all of them hit.
- R12: `cpu_ready` is high only while idle, so at most one access is outstanding. `cpu_resp` is a single-cycle pulse, followed by the return to idle. A write's response carries the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_valid | input | 1 | Requester presents an access |
| cpu_ready | output | 1 | Block accepts an access (idle) |
| cpu_write | input | 1 | 1 = write byte, 0 = read byte |
| cpu_addr | input | ADDR_W (32) | Byte address |
| cpu_wdata | input | 8 | Byte to write |
| cpu_resp | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Read byte (written byte for writes), valid with cpu_resp |
| mem_valid | output | 1 | Memory beat requested |
| mem_ready | input | 1 | Memory takes or delivers the beat this cycle |
| mem_write | output | 1 | 1 = copy-back beat, 0 = fetch beat |
| mem_addr | output | ADDR_W (32) | Beat byte address, 8-byte aligned |
| mem_wdata | output | 64 | Copy-back beat data |
| mem_rdata | input | 64 | Fetch beat data, taken when mem_valid and mem_ready are high |

## Verification
The bound checker watches the memory side and the requester side on every cycle. It checks that a stalled beat holds its address and direction, that beats within a line step up by one, that a copy-back is followed directly by the fetch from beat 0, that a hit yields a response in the next cycle, that a finished fetch is followed by a hitting lookup, and that the response is a lone pulse while busy. The bench scenarios cover what depends on stored contents and history. These are the data returned after writes and evictions, the choice of empty ways before the rotating counter, the exact old-line address of each copy-back, and whether a replaced line was modified.

// File: rtl/sa_cache_pkg.sv
package sa_cache_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LOOKUP  = 3'd1,
        ST_WRBACK  = 3'd2,
        ST_REFILL  = 3'd3,
        ST_RESPOND = 3'd4
    } ctl_state_e;

endpackage

// File: rtl/sa_cache_tags.sv
module sa_cache_tags #(
    parameter int WAYS  = 8,
    parameter int SETS  = 64,
    parameter int TAG_W = 20
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [$clog2(SETS)-1:0]        lk_set,
    input  logic [TAG_W-1:0]               lk_tag,
    input  logic                           fill_en,
    input  logic [$clog2(WAYS)-1:0]        fill_way,
    input  logic                           dirty_en,
    input  logic [$clog2(WAYS)-1:0]        dirty_way,
    output logic [WAYS-1:0]                hit_vec,
    output logic [WAYS-1:0]                valid_vec,
    output logic [WAYS-1:0]                dirty_vec,
    output logic [WAYS-1:0][TAG_W-1:0]     way_tags
);

    localparam int WAY_W = $clog2(WAYS);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [TAG_W-1:0] tag_mem [SETS];
        logic [SETS-1:0]  vld_d, vld_q;
        logic [SETS-1:0]  drt_d, drt_q;
        logic             fill_me, dirty_me;

        assign fill_me  = fill_en  && (fill_way  == WAY_W'(w));
        assign dirty_me = dirty_en && (dirty_way == WAY_W'(w));

        always_ff @(posedge clk) begin
            if (fill_me) begin
                tag_mem[lk_set] <= lk_tag;
            end
        end

        always_comb begin
            vld_d = vld_q;
            drt_d = drt_q;
            if (fill_me) begin
                vld_d[lk_set] = 1'b1;
                drt_d[lk_set] = 1'b0;
            end else if (dirty_me) begin
                drt_d[lk_set] = 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q <= '0;
                drt_q <= '0;
            end else begin
                vld_q <= vld_d;
                drt_q <= drt_d;
            end
        end

        assign way_tags[w]  = tag_mem[lk_set];
        assign valid_vec[w] = vld_q[lk_set];
        assign dirty_vec[w] = drt_q[lk_set];
        assign hit_vec[w]   = vld_q[lk_set] && (tag_mem[lk_set] == lk_tag);
    end

endmodule

// File: rtl/sa_cache_lines.sv
module sa_cache_lines #(
    parameter int WAYS       = 8,
    parameter int SETS       = 64,
    parameter int LINE_BYTES = 64,
    parameter int BEAT_BYTES = 8
) (
    input  logic                                     clk,
    input  logic [$clog2(SETS)-1:0]                  set_idx,
    input  logic [$clog2(WAYS)-1:0]                  way_idx,
    input  logic [$clog2(LINE_BYTES)-1:0]            byte_off,
    input  logic [$clog2(LINE_BYTES/BEAT_BYTES)-1:0] beat_idx,
    input  logic                                     byte_we,
    input  logic [7:0]                               byte_wdata,
    input  logic                                     beat_we,
    input  logic [BEAT_BYTES*8-1:0]                  beat_wdata,
    output logic [7:0]                               byte_rdata,
    output logic [BEAT_BYTES*8-1:0]                  beat_rdata
);

    localparam int WAY_W      = $clog2(WAYS);
    localparam int LINE_BITS  = LINE_BYTES * 8;
    localparam int BEAT_BITS  = BEAT_BYTES * 8;
    localparam int BEAT_OFF_W = $clog2(BEAT_BYTES);

    logic [LINE_BITS-1:0] line_rd [WAYS];
    logic [LINE_BITS-1:0] sel_line;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [LINE_BITS-1:0] line_mem [SETS];
        logic                 mine;

        assign mine = (way_idx == WAY_W'(w));

        always_ff @(posedge clk) begin
            if (mine && byte_we) begin
                line_mem[set_idx][{byte_off, 3'b000} +: 8] <= byte_wdata;
            end
            if (mine && beat_we) begin
                line_mem[set_idx][{beat_idx, {(BEAT_OFF_W+3){1'b0}}} +: BEAT_BITS] <= beat_wdata;
            end
        end

        assign line_rd[w] = line_mem[set_idx];
    end

    assign sel_line   = line_rd[way_idx];
    assign byte_rdata = sel_line[{byte_off, 3'b000} +: 8];
    assign beat_rdata = sel_line[{beat_idx, {(BEAT_OFF_W+3){1'b0}}} +: BEAT_BITS];

endmodule

// File: rtl/sa_cache_victim.sv
module sa_cache_victim #(
    parameter int WAYS = 8,
    parameter int SETS = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(SETS)-1:0] set_idx,
    input  logic [WAYS-1:0]         valid_vec,
    input  logic                    alloc,
    output logic [$clog2(WAYS)-1:0] vict_way
);

    localparam int WAY_W = $clog2(WAYS);

    logic [SETS-1:0][WAY_W-1:0] cnt_d, cnt_q;
    logic [WAY_W-1:0]           free_way;
    logic                       set_full;

    always_comb begin
        free_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_way = WAY_W'(i);
            end
        end
    end

    assign set_full = &valid_vec;
    assign vict_way = set_full ? cnt_q[set_idx] : free_way;

    always_comb begin
        cnt_d = cnt_q;
        if (alloc && set_full) begin
            cnt_d[set_idx] = cnt_q[set_idx] + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/sa_cache.sv
module sa_cache
    import sa_cache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WAYS       = 8,
    parameter int SETS       = 64,
    parameter int LINE_BYTES = 64,
    parameter int BEAT_BYTES = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_valid,
    output logic                    cpu_ready,
    input  logic                    cpu_write,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [7:0]              cpu_wdata,
    output logic                    cpu_resp,
    output logic [7:0]              cpu_rdata,
    output logic                    mem_valid,
    input  logic                    mem_ready,
    output logic                    mem_write,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [BEAT_BYTES*8-1:0] mem_wdata,
    input  logic [BEAT_BYTES*8-1:0] mem_rdata
);

    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int SET_W      = $clog2(SETS);
    localparam int TAG_W      = ADDR_W - OFF_W - SET_W;
    localparam int WAY_W      = $clog2(WAYS);
    localparam int BEATS      = LINE_BYTES / BEAT_BYTES;
    localparam int BEAT_W     = $clog2(BEATS);
    localparam int BEAT_OFF_W = $clog2(BEAT_BYTES);

    typedef struct packed {
        ctl_state_e         st;
        logic [ADDR_W-1:0]  addr;
        logic               wr;
        logic [7:0]         wdata;
        logic [WAY_W-1:0]   way;
        logic [BEAT_W-1:0]  beat;
        logic [7:0]         rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [SET_W-1:0]             cur_set;
    logic [TAG_W-1:0]             cur_tag;
    logic [OFF_W-1:0]             cur_off;
    logic [WAYS-1:0]              hit_vec, valid_vec, dirty_vec;
    logic [WAYS-1:0][TAG_W-1:0]   way_tags;
    logic                         hit_any;
    logic [WAY_W-1:0]             hit_way;
    logic [WAY_W-1:0]             vict_way;
    logic [WAY_W-1:0]             acc_way;
    logic                         byte_we, beat_we, fill_en, dirty_en, alloc;
    logic [7:0]                   byte_rdata;
    logic [BEAT_BYTES*8-1:0]      beat_rdata;
    logic                         last_beat;
    ctl_state_e                   cur_st;

    assign cur_set   = ctl_q.addr[OFF_W +: SET_W];
    assign cur_tag   = ctl_q.addr[ADDR_W-1 -: TAG_W];
    assign cur_off   = ctl_q.addr[OFF_W-1:0];
    assign last_beat = (ctl_q.beat == BEAT_W'(BEATS - 1));
    assign cur_st    = ctl_q.st;

    sa_cache_tags #(
        .WAYS  (WAYS),
        .SETS  (SETS),
        .TAG_W (TAG_W)
    ) i_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_set    (cur_set),
        .lk_tag    (cur_tag),
        .fill_en   (fill_en),
        .fill_way  (ctl_q.way),
        .dirty_en  (dirty_en),
        .dirty_way (hit_way),
        .hit_vec   (hit_vec),
        .valid_vec (valid_vec),
        .dirty_vec (dirty_vec),
        .way_tags  (way_tags)
    );

    sa_cache_lines #(
        .WAYS       (WAYS),
        .SETS       (SETS),
        .LINE_BYTES (LINE_BYTES),
        .BEAT_BYTES (BEAT_BYTES)
    ) i_lines (
        .clk        (clk),
        .set_idx    (cur_set),
        .way_idx    (acc_way),
        .byte_off   (cur_off),
        .beat_idx   (ctl_q.beat),
        .byte_we    (byte_we),
        .byte_wdata (ctl_q.wdata),
        .beat_we    (beat_we),
        .beat_wdata (mem_rdata),
        .byte_rdata (byte_rdata),
        .beat_rdata (beat_rdata)
    );

    sa_cache_victim #(
        .WAYS (WAYS),
        .SETS (SETS)
    ) i_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_idx   (cur_set),
        .valid_vec (valid_vec),
        .alloc     (alloc),
        .vict_way  (vict_way)
    );

    // Way-hit encoder: at most one way matches a given tag
    always_comb begin
        hit_way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (hit_vec[i]) begin
                hit_way = WAY_W'(i);
            end
        end
    end
    assign hit_any = |hit_vec;

    always_comb begin
        ctl_d     = ctl_q;
        byte_we   = 1'b0;
        beat_we   = 1'b0;
        fill_en   = 1'b0;
        dirty_en  = 1'b0;
        alloc     = 1'b0;
        acc_way   = ctl_q.way;
        mem_valid = 1'b0;
        mem_write = 1'b0;
        mem_addr  = {cur_tag, cur_set, ctl_q.beat, {BEAT_OFF_W{1'b0}}};

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (cpu_valid) begin
                    ctl_d.addr  = cpu_addr;
                    ctl_d.wr    = cpu_write;
                    ctl_d.wdata = cpu_wdata;
                    ctl_d.st    = ST_LOOKUP;
                end
            end
            ST_LOOKUP: begin
                acc_way = hit_way;
                if (hit_any) begin
                    if (ctl_q.wr) begin
                        byte_we     = 1'b1;
                        dirty_en    = 1'b1;
                        ctl_d.rdata = ctl_q.wdata;
                    end else begin
                        ctl_d.rdata = byte_rdata;
                    end
                    ctl_d.st = ST_RESPOND;
                end else begin
                    alloc      = 1'b1;
                    ctl_d.way  = vict_way;
                    ctl_d.beat = '0;
                    if (valid_vec[vict_way] && dirty_vec[vict_way]) begin
                        ctl_d.st = ST_WRBACK;
                    end else begin
                        ctl_d.st = ST_REFILL;
                    end
                end
            end
            ST_WRBACK: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = {way_tags[ctl_q.way], cur_set, ctl_q.beat, {BEAT_OFF_W{1'b0}}};
                if (mem_ready) begin
                    ctl_d.beat = ctl_q.beat + 1'b1;
                    if (last_beat) begin
                        ctl_d.beat = '0;
                        ctl_d.st   = ST_REFILL;
                    end
                end
            end
            ST_REFILL: begin
                mem_valid = 1'b1;
                if (mem_ready) begin
                    beat_we    = 1'b1;
                    ctl_d.beat = ctl_q.beat + 1'b1;
                    if (last_beat) begin
                        fill_en    = 1'b1;
                        ctl_d.beat = '0;
                        ctl_d.st   = ST_LOOKUP;
                    end
                end
            end
            ST_RESPOND: begin
                ctl_d.st = ST_IDLE;
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cpu_ready = (ctl_q.st == ST_IDLE);
    assign cpu_resp  = (ctl_q.st == ST_RESPOND);
    assign cpu_rdata = ctl_q.rdata;
    assign mem_wdata = beat_rdata;

endmodule

// File: rtl/sa_cache_chk.sv
module sa_cache_chk
    import sa_cache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int BEAT_BYTES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ready,
    input logic              cpu_resp,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_write,
    input logic [ADDR_W-1:0] mem_addr,
    input ctl_state_e        st,
    input logic              hit_any
);

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int BOFF_W = $clog2(BEAT_BYTES);
    localparam int BEAT_W = OFF_W - BOFF_W;

    logic [BEAT_W-1:0] beat_no;
    logic              beat_done, beat_last;

    assign beat_no   = mem_addr[OFF_W-1:BOFF_W];
    assign beat_done = mem_valid && mem_ready;
    assign beat_last = beat_done && (beat_no == {BEAT_W{1'b1}});

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write))); // R8

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_done && !beat_last) |=> (mem_valid && $stable(mem_write)
            && $stable(mem_addr[ADDR_W-1:OFF_W])
            && (beat_no == BEAT_W'($past(beat_no) + 1'b1)))); // R8

    AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_last && mem_write) |=> (mem_valid && !mem_write && (beat_no == '0))); // R7

    AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_last && !mem_write) |=> ((st == ST_LOOKUP) && hit_any)); // R10

    AST_HIT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_LOOKUP) && hit_any) |=> (cpu_resp && !mem_valid)); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> (!mem_valid && !cpu_resp)); // R12

    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_resp |=> (!cpu_resp && cpu_ready)); // R12

endmodule

bind sa_cache sa_cache_chk #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .BEAT_BYTES (BEAT_BYTES)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_ready (cpu_ready),
    .cpu_resp  (cpu_resp),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_write (mem_write),
    .mem_addr  (mem_addr),
    .st        (cur_st),
    .hit_any   (hit_any)
);

// File: tb/test_sa_cache.sv
module test_sa_cache;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_valid, cpu_ready, cpu_write, cpu_resp;
    logic [31:0] cpu_addr;
    logic [7:0]  cpu_wdata, cpu_rdata;
    logic        mem_valid, mem_ready, mem_write;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata, mem_rdata;

    always #10 clk = ~clk;

    sa_cache i_sa_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_valid (cpu_valid),
        .cpu_ready (cpu_ready),
        .cpu_write (cpu_write),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_resp  (cpu_resp),
        .cpu_rdata (cpu_rdata),
        .mem_valid (mem_valid),
        .mem_ready (mem_ready),
        .mem_write (mem_write),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    // Backing memory: 64 KB window, 8-byte words, owned by the monitor process
    logic [63:0] mem [8192];
    logic [63:0] ref_mem [8192];
    int          rd_total = 0, wr_total = 0, idx_err = 0;
    int          cyc = 0, first_rd_stamp = 0, last_wr_stamp = 0;
    logic [31:0] wb_line = '0, rd_line = '0;
    logic [15:0] lfsr = 16'hACE1;

    function automatic logic [7:0] init_byte(input int a);
        return 8'((a * 37) ^ (a >> 5));
    endfunction

    assign mem_rdata = mem[mem_addr[15:3]];

    initial begin
        for (int i = 0; i < 8192; i++) begin
            for (int k = 0; k < 8; k++) begin
                mem[i][k*8 +: 8] = init_byte(i * 8 + k);
            end
        end
        mem_ready = 1'b1;
        forever begin
            @(negedge clk);
            cyc++;
            lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_ready = lfsr[0] | lfsr[3];
            if (mem_valid && mem_ready) begin
                if (mem_addr[31:16] != 16'h0 || mem_addr[2:0] != 3'd0) idx_err++;
                if (mem_write) begin
                    if (mem_addr[5:3] != 3'(wr_total % 8)) idx_err++;
                    mem[mem_addr[15:3]] = mem_wdata;
                    wr_total++;
                    last_wr_stamp = cyc;
                    wb_line = mem_addr & ~32'h3f;
                end else begin
                    if (mem_addr[5:3] != 3'(rd_total % 8)) idx_err++;
                    if (rd_total % 8 == 0) begin
                        first_rd_stamp = cyc;
                        rd_line = mem_addr & ~32'h3f;
                    end
                    rd_total++;
                end
            end
        end
    end

    int          n_chk = 0, n_fail = 0;
    logic [7:0]  g_rdata;
    int          g_lat, g_rd, g_wr;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_byte(input logic [31:0] a);
        return ref_mem[a[15:3]][{a[2:0], 3'b000} +: 8];
    endfunction

    task automatic access(input bit wr, input logic [31:0] a, input logic [7:0] d);
        int r0, w0, e0;
        bit busy_bad;
        r0 = rd_total; w0 = wr_total; e0 = idx_err;
        cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_valid = 1'b0;
        g_lat = 1; busy_bad = 1'b0;
        while (!cpu_resp) begin
            if (cpu_ready) busy_bad = 1'b1;
            @(negedge clk);
            g_lat++;
        end
        g_rdata = cpu_rdata;
        g_rd = rd_total - r0;
        g_wr = wr_total - w0;
        if (wr) begin
            chk(g_rdata == d, "R12 write response byte", g_rdata, d);
            ref_mem[a[15:3]][{a[2:0], 3'b000} +: 8] = d;
        end else begin
            chk(g_rdata == ref_byte(a), "R4 read data", g_rdata, ref_byte(a));
        end
        chk(!busy_bad, "R12 ready low while busy", busy_bad, 0);
        chk(idx_err == e0, "R8 beat order and alignment", idx_err - e0, 0);
        chk(g_rd == 0 || g_rd == 8, "R6 refill beat count", g_rd, 8);
        chk(g_wr == 0 || (g_wr == 8 && g_rd == 8), "R7 copy-back beat count", g_wr, 8);
        if (g_wr == 8) chk(last_wr_stamp < first_rd_stamp, "R7 copy-back before refill",
                           last_wr_stamp, first_rd_stamp);
        @(negedge clk);
        chk(!cpu_resp && cpu_ready, "R12 single response pulse", cpu_resp, 0);
    endtask

    task automatic run_all();
        logic [31:0] a;
        // R1 reset state
        chk(cpu_ready == 1'b1, "R1 ready after reset", cpu_ready, 1);
        chk(cpu_resp == 1'b0, "R1 no response after reset", cpu_resp, 0);
        chk(mem_valid == 1'b0, "R1 no memory beat after reset", mem_valid, 0);

        // Cold read miss: set 8, tag 1
        a = 32'h0000_1234;
        access(1'b0, a, 8'h00);
        chk(g_rd == 8 && g_wr == 0, "R1 cold miss fetches", g_rd + 100 * g_wr, 8);
        chk(rd_line == (a & ~32'h3f), "R8 refill line base", int'(rd_line), int'(a & ~32'h3f));

        // Every offset of that line hits (R2 byte select, R3 latency)
        for (int o = 0; o < 64; o++) begin
            access(1'b0, (a & ~32'h3f) | 32'(o), 8'h00);
            chk(g_rd == 0 && g_wr == 0, "R3 hit has no beats", g_rd + g_wr, 0);
            chk(g_lat == 2, "R3 hit latency", g_lat, 2);
        end

        // R5 write hit, read back
        access(1'b1, (a & ~32'h3f) | 32'd5, 8'hA5);
        chk(g_rd == 0 && g_wr == 0 && g_lat == 2, "R5 write hit local", g_lat, 2);
        access(1'b0, (a & ~32'h3f) | 32'd5, 8'h00);
        chk(g_rdata == 8'hA5, "R5 written byte read back", g_rdata, 8'hA5);
        access(1'b0, (a & ~32'h3f) | 32'd4, 8'h00);
        chk(g_rdata == init_byte(int'(a & ~32'h3f) + 4), "R5 neighbour byte untouched",
            g_rdata, init_byte(int'(a & ~32'h3f) + 4));

        // Set 5: write misses to tags 0..7 fill empty ways (R9, R10)
        for (int t = 0; t < 8; t++) begin
            access(1'b1, 32'((t << 12) | (5 << 6) | t), 8'(8'h40 + t));
            chk(g_rd == 8 && g_wr == 0, "R10 write miss allocates, no copy-back", g_wr, 0);
        end
        for (int t = 0; t < 8; t++) begin
            access(1'b0, 32'((t << 12) | (5 << 6) | t), 8'h00);
            chk(g_rd == 0 && g_lat == 2, "R11 eight tags coexist in one set", g_rd, 0);
            chk(g_rdata == 8'(8'h40 + t), "R10 write miss data", g_rdata, 8'h40 + t);
        end

        // Set 5 full: tags 8..15 replace ways 0..7 in turn (R9), dirty copy-back (R7, R5)
        for (int k = 0; k < 8; k++) begin
            access(1'b0, 32'(((k + 8) << 12) | (5 << 6) | 9), 8'h00);
            chk(g_wr == 8 && g_rd == 8, "R7 dirty victim copied back", g_wr, 8);
            chk(wb_line == 32'((k << 12) | (5 << 6)), "R9 round-robin victim line",
                int'(wb_line), (k << 12) | (5 << 6));
            chk(mem[(k << 9) | (5 << 3)][k*8 +: 8] == 8'(8'h40 + k), "R5 copied-back byte",
                mem[(k << 9) | (5 << 3)][k*8 +: 8], 8'h40 + k);
        end
        // Counter wrapped to way 0, now a clean line (tag 8)
        access(1'b0, 32'((0 << 12) | (5 << 6) | 0), 8'h00);
        chk(g_wr == 0 && g_rd == 8, "R6 clean victim, refill only", g_wr, 0);
        chk(g_rdata == 8'h40, "R4 data survives eviction", g_rdata, 8'h40);

        // Near-exhaustive mixed sweep over 4 sets and 16 tags
        for (int i = 0; i < 600; i++) begin
            a = 32'((((i * 5) % 16) << 12) | ((20 + i % 4) << 6) | ((i * 11) % 64));
            access(i % 3 == 0, a, 8'(i * 13 + 7));
        end
    endtask

    initial begin
        bit timed_out;
        timed_out = 1'b0;
        for (int i = 0; i < 8192; i++) begin
            for (int k = 0; k < 8; k++) begin
                ref_mem[i][k*8 +: 8] = init_byte(i * 8 + k);
            end
        end
        rst_n = 1'b0; cpu_valid = 1'b0; cpu_write = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        fork
            run_all();
            begin
                repeat (200000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) chk(1'b0, "watchdog expired", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule